// File: doc/BRIEF.md
# Multiphase Coincidence Window Detector

The block decides whether two asynchronous event inputs rise close enough together to be called coincident. The gap between the two rising edges shows up as a pulse on the exclusive-OR of the inputs. A row of sampling flags watches that pulse. Each flag is clocked by its own copy of the reference clock, and copy k lags the reference by k/N of a period. A flag is set when its clock edge finds the inputs unequal, and it stays set until the block clears it. The number of set flags, F, measures the gap in steps of one N-th of a reference period. When F is below N the gap is shorter than the window, which is one reference period, and the block reports a hit.

The flags are brought into the reference domain through two-stage synchronizers. The moment when both inputs are high is also synchronized, and that moment starts the decision. The block takes the flag count two reference cycles later, publishes it, and raises a one-cycle hit strobe if F is below N. It then clears every flag and stays in a re-arm period. The re-arm period lasts at least two cycles, and until both inputs have gone low again. Anything that happens on the inputs during re-arm is ignored. The phase clocks are supplied from outside the block.

Top module: `cwd_detector`

## Requirements
- R1: Each phase flag samples A XOR B on the rising edge of its own phase clock. Once set, it holds until the block clears it. With the XOR pulse starting half a phase step after a phase edge and lasting j phase steps, exactly min(j, N) flags are set.
- R2: At each decision, gap_count is loaded with F, the number of set flags, whether or not a hit is reported. F = k < N means the gap lies between (k-1)/N and (k+1)/N of a reference period. F = N means the gap is longer than (N-1)/N of a period.
- R3: If F < N at the decision, hit is high for exactly one reference cycle.
- R4: If F = N at the decision, meaning every phase saw the pulse, hit stays low.
- R5: A decision starts when the synchronized A AND B rises while the block is armed. The count is taken two reference cycles after that start, and there is exactly one decision per rise.
- R6: On a decision, every flag is cleared. The clear is held for at least two reference cycles, and until the synchronized A OR B is low. Input activity during that time (for example an input dropping and rising again, or staggered falling edges) causes no hit and leaves no flag behind for the next event.
- R7: While rst_n is low (synchronous, active low), hit is 0 and gap_count is 0, and the flags are held clear.
- R8: The result does not depend on which input rises first.
- R9: If both inputs rise in the same instant, F = 0 and a hit is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; its period is the coincidence window |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_a | input | 1 | First asynchronous event input |
| ev_b | input | 1 | Second asynchronous event input |
| phase_clk | input | N | Phase clocks; bit k lags clk by k/N of a period |
| hit | output | 1 | One-cycle coincidence strobe |
| gap_count | output | clog2(N+1) | Flag count F from the latest decision |

## Verification
The assertions take for granted that events are spaced apart. Both inputs return low, and stay low for several reference cycles, before the next rise. A new rise therefore always finds the block armed, with its flags clear. The stimulus builds every phase clock and the reference clock from a single tick counter running at half a phase step. It drives the inputs only on odd ticks, so no input change ever coincides with a clock edge, and the expected flag count is exact. Each event holds both inputs high for eight reference cycles and leaves them low for ten. This is well beyond the synchronizer, settle and re-arm latency.

// File: rtl/cwd_pkg.sv
// Shared types for the coincidence window detector.
package cwd_pkg;
    // Controller states: waiting for an event, settling, clearing flags
    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_REARM  = 2'd2
    } cwd_state_e;
endpackage

// File: rtl/cwd_phase_flag.sv
// One sampling flag, clocked by a single phase clock.
// It sets when its edge finds the gap signal high and holds until clr.
// Assumes clr is held long enough for at least one edge of this phase clock.
module cwd_phase_flag (
    input  logic phase_clk,
    input  logic clr,
    input  logic gap,
    output logic flag
);
    // Set-and-hold sampler with a clear that takes priority
    always_ff @(posedge phase_clk) begin
        if (clr)
            flag <= 1'b0;
        else if (gap)
            flag <= 1'b1;
    end
endmodule

// File: rtl/cwd_sync2.sv
// Two-stage synchronizer for a bus of independent bits, in the clk domain.
// Assumes each bit is a level that changes slowly compared with clk.
module cwd_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    // Two flop stages, cleared by the synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/cwd_popcount.sv
// Counts the set bits of a flag vector. Purely combinational.
module cwd_popcount #(
    parameter int N  = 12,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits,
    output logic [CW-1:0] total
);
    // Add the flags one at a time
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++)
            total = total + CW'(bits[i]);
    end
endmodule

// File: rtl/cwd_ctrl.sv
// Decision controller in the reference domain.
// A rise of the synchronized both-high signal starts a decision. The count
// is taken SETTLE cycles later, and hit is raised if the count is below N.
// The flags are then cleared for at least REARM cycles, and until neither
// input is high.
// Assumes both_s and any_s are already synchronized to clk.
module cwd_ctrl
    import cwd_pkg::*;
#(
    parameter int N      = 12,
    parameter int CW     = $clog2(N + 1),
    parameter int SETTLE = 2,
    parameter int REARM  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          both_s,
    input  logic          any_s,
    input  logic [CW-1:0] tally,
    output logic          hit,
    output logic [CW-1:0] gap_count,
    output logic          flag_clr
);
    localparam int MAXW = (SETTLE > REARM) ? SETTLE : REARM;
    localparam int TW   = $clog2(MAXW + 1);

    cwd_state_e    state, state_d;
    logic [TW-1:0] cnt, cnt_d;
    logic          both_q;
    logic          trig;
    logic          decide;

    assign trig = both_s & ~both_q;

    // Next-state logic for the arm, settle and re-arm sequence
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        decide  = 1'b0;
        case (state)
            ST_ARMED: begin
                if (trig) begin
                    state_d = ST_SETTLE;
                    cnt_d   = '0;
                end
            end
            ST_SETTLE: begin
                if (cnt == TW'(SETTLE - 1)) begin
                    decide  = 1'b1;
                    state_d = ST_REARM;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end
            ST_REARM: begin
                if (cnt >= TW'(REARM - 1)) begin
                    if (!any_s)
                        state_d = ST_ARMED;
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // State, edge-detect and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_ARMED;
            cnt       <= '0;
            both_q    <= 1'b0;
            hit       <= 1'b0;
            gap_count <= '0;
            flag_clr  <= 1'b1;
        end else begin
            state    <= state_d;
            cnt      <= cnt_d;
            both_q   <= both_s;
            hit      <= decide && (tally < CW'(N));
            flag_clr <= (state_d == ST_REARM);
            if (decide)
                gap_count <= tally;
        end
    end
endmodule

// File: rtl/cwd_detector.sv
// Top level of the multiphase coincidence window detector.
// The phase flags are arranged as GROUPS groups of PER_GROUP phases.
// Assumes phase_clk[k] lags clk by k/N of a period, and that ev_a and
// ev_b are asynchronous levels.
module cwd_detector #(
    parameter int GROUPS    = 3,
    parameter int PER_GROUP = 4,
    parameter int N         = GROUPS * PER_GROUP,
    parameter int CW        = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_a,
    input  logic          ev_b,
    input  logic [N-1:0]  phase_clk,
    output logic          hit,
    output logic [CW-1:0] gap_count
);
    logic          gap;
    logic [N-1:0]  flags;
    logic [N-1:0]  flags_s;
    logic [1:0]    lvl_s;
    logic [CW-1:0] tally;
    logic          flag_clr;

    assign gap = ev_a ^ ev_b;

    // One flag per phase, laid out group by group
    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        for (genvar p = 0; p < PER_GROUP; p++) begin : g_phase
            cwd_phase_flag u_flag (
                .phase_clk (phase_clk[g*PER_GROUP + p]),
                .clr       (flag_clr),
                .gap       (gap),
                .flag      (flags[g*PER_GROUP + p])
            );
        end
    end

    cwd_sync2 #(.W(N)) u_flag_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (flags),
        .dout  (flags_s)
    );

    cwd_sync2 #(.W(2)) u_lvl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ev_a & ev_b, ev_a | ev_b}),
        .dout  (lvl_s)
    );

    cwd_popcount #(.N(N), .CW(CW)) u_count (
        .bits  (flags_s),
        .total (tally)
    );

    cwd_ctrl #(.N(N), .CW(CW), .SETTLE(2), .REARM(2)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .both_s    (lvl_s[1]),
        .any_s     (lvl_s[0]),
        .tally     (tally),
        .hit       (hit),
        .gap_count (gap_count),
        .flag_clr  (flag_clr)
    );
endmodule

// File: rtl/cwd_detector_chk.sv
// Property checker for cwd_detector, attached with bind.
module cwd_detector_chk #(
    parameter int N  = 12,
    parameter int CW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hit,
    input logic [CW-1:0] gap_count,
    input logic          flag_clr
);
    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R3
    AST_HIT_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (gap_count < CW'(N))); // R4
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        gap_count <= CW'(N)); // R2
    AST_CLEAR_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> flag_clr); // R6
    AST_CLEAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_clr) |=> flag_clr); // R6
    AST_NO_HIT_IN_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && $past(flag_clr)) |-> !hit); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!hit && gap_count == '0)); // R7
endmodule

bind cwd_detector cwd_detector_chk #(.N(N), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .gap_count (gap_count),
    .flag_clr  (flag_clr)
);

// File: tb/sim_cwd_detector.sv
`timescale 1ns/1ps
module sim_cwd_detector;
    localparam int N       = 12;
    localparam int CW      = $clog2(N + 1);
    localparam int PER     = 2 * N;          // ticks per reference period
    localparam realtime TICK = 20.0 / PER;   // half a phase step, 50 MHz ref

    // vectors: {B rises first, start offset (odd tick in period), gap in phase steps}
    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{0, 1,  0},
        '{0, 3,  1},
        '{1, 5,  3},
        '{0, 7,  6},
        '{1, 9, 11},
        '{0, 11, 12},
        '{1, 13, 13},
        '{0, 17, 20}
    };

    logic          clk;
    logic          rst_n;
    logic          ev_a;
    logic          ev_b;
    logic [N-1:0]  phase_clk;
    logic          hit;
    logic [CW-1:0] gap_count;

    int tick   = 0;
    int hits   = 0;
    int errors = 0;
    int checks = 0;
    bit done   = 0;

    cwd_detector u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_a      (ev_a),
        .ev_b      (ev_b),
        .phase_clk (phase_clk),
        .hit       (hit),
        .gap_count (gap_count)
    );

    // All clocks from one tick counter: phase k rises at ticks 2k mod PER
    initial begin
        logic [N-1:0] nxt;
        for (int k = 0; k < N; k++)
            nxt[k] = ((((0 - 2*k) % PER) + PER) % PER) < N;
        phase_clk = nxt;
        clk = nxt[0];
        forever begin
            #(TICK);
            tick++;
            for (int k = 0; k < N; k++)
                nxt[k] = ((((tick - 2*k) % PER) + PER) % PER) < N;
            phase_clk = nxt;
            clk = nxt[0];
        end
    end

    // Count hit strobes away from the active edge
    always @(negedge clk) begin
        if (hit) hits++;
    end

    task automatic wait_tick(input int t);
        while (tick < t) @(tick);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One event: the first input rises at the offset, the second j steps later.
    // glitch_b drops B for three ticks during the hold; stagger makes the falls j2 steps apart.
    task automatic run_event(input int b_first, input int off, input int j,
                             input bit glitch_b, input int stagger, input string req);
        int t0;
        int h0;
        int exp_f;
        t0 = ((tick / PER) + 2) * PER + off;
        h0 = hits;
        wait_tick(t0);
        if (b_first != 0) ev_b = 1'b1; else ev_a = 1'b1;
        wait_tick(t0 + 2*j);
        ev_a = 1'b1;
        ev_b = 1'b1;
        if (glitch_b) begin
            wait_tick(t0 + 2*j + 5*PER);
            ev_b = 1'b0;
            wait_tick(t0 + 2*j + 5*PER + 3);
            ev_b = 1'b1;
        end
        wait_tick(t0 + 2*j + 8*PER);
        ev_a = 1'b0;
        wait_tick(t0 + 2*j + 8*PER + 2*stagger);
        ev_b = 1'b0;
        wait_tick(t0 + 2*j + 8*PER + 2*stagger + 10*PER + 1);
        exp_f = (j < N) ? j : N;
        chk(gap_count == CW'(exp_f), {req, " count"}, int'(gap_count), exp_f);
        chk((hits - h0) == ((j < N) ? 1 : 0), {req, " hits"}, hits - h0, (j < N) ? 1 : 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(200000 * 20.0);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ev_a  = 1'b0;
        ev_b  = 1'b0;
        wait_tick(3*PER + 1);
        chk(hit == 1'b0, "R7 hit in reset", int'(hit), 0);
        chk(gap_count == '0, "R7 count in reset", int'(gap_count), 0);
        wait_tick(4*PER + 12 + 1);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R8 R9: table walk
        for (int v = 0; v < NV; v++)
            run_event(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0, 0, "R1 R2 R3 R4 R5 R8 R9 table");

        // R8: the same gap with the order swapped
        run_event(0, 5, 3, 1'b0, 0, "R8 A first");
        run_event(1, 5, 3, 1'b0, 0, "R8 B first");

        // R6: B dips during re-arm, falls are staggered; no extra hit
        run_event(0, 3, 2, 1'b1, 5, "R6 rearm activity");
        // R6: the next event must see only its own gap
        run_event(1, 7, 4, 1'b0, 0, "R6 after stagger");

        // R7: reset mid-run clears the published count
        wait_tick(tick + PER + 1);
        rst_n = 1'b0;
        wait_tick(tick + 3*PER);
        chk(gap_count == '0, "R7 count after reset", int'(gap_count), 0);
        chk(hit == 1'b0, "R7 hit after reset", int'(hit), 0);
        rst_n = 1'b1;
        run_event(0, 9, 5, 1'b0, 0, "R2 R5 after reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule